// File: doc/BRIEF.md
# Processor status flags and branch decision unit

This block keeps the eight status flags of a small processor core and makes the decisions for conditional branches and bit-test branches. The arithmetic unit can update any subset of the flags through a per-flag write mask. A single operation code can also force one flag to 1 or 0, copy one bit of a general register into the transfer flag, or deposit the transfer flag into one bit of a register value.

For conditional branches, the block tests the flag chosen by a three-bit index, for either a set or a clear state. It then drives a taken strobe and the branch target. The target is the current program counter plus a sign-extended offset plus one. A branch on the sign-flag position uses N XOR V, taken from the current flags, so the signed greater-or-equal and less-than branches follow the overflow-corrected sign. Instruction fetch and the stack are outside this block. Of interrupt handling, only the global-enable flag is held here.

Top module: `status_branch_unit`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous) and immediately after it, all eight flags read 0. This includes the global interrupt enable, bit 7.
- R2: With op_code 0 (idle), on each clock edge every flag whose alu_we bit is 1 takes the matching alu_flags bit, and every flag whose alu_we bit is 0 keeps its value.
- R3: op_code 1 (flag set) makes flag[bit_sel] 1 at the next edge.
- R4: op_code 2 (flag clear) makes flag[bit_sel] 0 at the next edge.
- R5: op_code 3 (bit store) copies reg_in[bit_sel] into the transfer flag, bit 6, at the next edge.
- R6: op_code 4 (bit load) drives reg_out as reg_in with bit bit_sel replaced by the transfer flag. Every other op code drives reg_out equal to reg_in. Neither case changes the flags.
- R7: op_code 5 (branch if set) raises taken when flag[bit_sel] is 1. op_code 6 (branch if clear) raises taken when it is 0. This applies to every bit_sel except 4. With bit_sel 0 (carry), op_code 6 is the unsigned same-or-higher test and op_code 5 is the lower test.
- R8: With bit_sel 4, the branch condition is N XOR V (bit 2 XOR bit 3), not the stored bit 4. op_code 6 is then signed greater-or-equal and op_code 5 is signed less-than.
- R9: target equals pc_in + sign-extended k_in + 1, modulo 2^PC_W.
- R10: When a flag set or clear happens in the same cycle as an ALU update, the explicit value wins on the selected flag. The ALU still writes the other flags its mask enables.
- R11: taken is 0 whenever op_code is not 5 or 6.
- Flag positions, bit 7 down to 0: I, T, H, S, V, N, Z, C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 3 | 0 idle, 1 flag set, 2 flag clear, 3 bit store, 4 bit load, 5 branch if set, 6 branch if clear |
| bit_sel | input | 3 | Flag index or register bit index |
| alu_we | input | 8 | Per-flag write mask from the ALU |
| alu_flags | input | 8 | Flag values from the ALU |
| reg_in | input | 8 | General register operand |
| pc_in | input | PC_W | Current program counter |
| k_in | input | OFS_W | Signed branch offset |
| flags | output | 8 | Status flags |
| reg_out | output | 8 | Register value after bit load |
| taken | output | 1 | Branch condition true |
| target | output | PC_W | Branch destination |

## Verification
The bench builds the unit with PC_W = 10 and OFS_W = 7, which keeps the counter small. With that width, directed values reach wrap-around at both ends of the address space (0x3FF forward, 0 backward). They also reach the most negative offset of -64 and the most positive offset of +63. The signed branch is tested with N and V both set while the stored sign bit is 0, which separates the derived condition from the stored flag.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  localparam int FLAG_W = 8;
  localparam int IDX_W  = 3;
  localparam int C_POS = 0;
  localparam int Z_POS = 1;
  localparam int N_POS = 2;
  localparam int V_POS = 3;
  localparam int S_POS = 4;
  localparam int H_POS = 5;
  localparam int T_POS = 6;
  localparam int I_POS = 7;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_FSET  = 3'd1,
    OP_FCLR  = 3'd2,
    OP_TSTO  = 3'd3,
    OP_TLOAD = 3'd4,
    OP_BSET  = 3'd5,
    OP_BCLR  = 3'd6,
    OP_RSVD  = 3'd7
  } sbu_op_e;
endpackage

// File: rtl/sbu_flag_reg.sv
module sbu_flag_reg
  import sbu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  sbu_op_e           op,
  input  logic [IDX_W-1:0]  sel,
  input  logic [FLAG_W-1:0] alu_we,
  input  logic [FLAG_W-1:0] alu_flags,
  input  logic              t_src,
  output logic [FLAG_W-1:0] flags_q
);
  logic [FLAG_W-1:0] alu_merged;
  logic [FLAG_W-1:0] flags_d;

  always_comb begin
    for (int i = 0; i < FLAG_W; i++)
      alu_merged[i] = alu_we[i] ? alu_flags[i] : flags_q[i];
  end

  always_comb begin
    flags_d = alu_merged;
    case (op)
      OP_FSET: flags_d[sel]   = 1'b1;
      OP_FCLR: flags_d[sel]   = 1'b0;
      OP_TSTO: flags_d[T_POS] = t_src;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  a_r1_reset_zero: assert property (@(posedge clk) $rose(rst_n) |-> (flags_q == '0));
  a_r3_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_FSET) |=> flags_q[$past(sel)]);
  a_r4_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_FCLR) |=> !flags_q[$past(sel)]);
  a_r2_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE) |=> (((flags_q ^ $past(flags_q)) & ~$past(alu_we)) == '0));
  a_r5_store_t: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_TSTO) |=> (flags_q[T_POS] == $past(t_src)));
endmodule

// File: rtl/sbu_bit_xfer.sv
module sbu_bit_xfer
  import sbu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  sbu_op_e           op,
  input  logic [IDX_W-1:0]  sel,
  input  logic [FLAG_W-1:0] reg_in,
  input  logic              t_flag,
  output logic              t_src,
  output logic [FLAG_W-1:0] reg_out
);
  function automatic logic [FLAG_W-1:0] put_bit(input logic [FLAG_W-1:0] v,
                                                input logic [IDX_W-1:0] pos,
                                                input logic b);
    logic [FLAG_W-1:0] r;
    r = v;
    r[pos] = b;
    return r;
  endfunction

  assign t_src   = reg_in[sel];
  assign reg_out = (op == OP_TLOAD) ? put_bit(reg_in, sel, t_flag) : reg_in;

  a_r6_other_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_TLOAD) |-> (((reg_out ^ reg_in) & ~(8'd1 << sel)) == '0));
  a_r6_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_TLOAD) |-> (reg_out == reg_in));
endmodule

// File: rtl/sbu_branch_eval.sv
module sbu_branch_eval
  import sbu_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFS_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sbu_op_e           op,
  input  logic [IDX_W-1:0]  sel,
  input  logic [FLAG_W-1:0] flags,
  input  logic [PC_W-1:0]   pc,
  input  logic [OFS_W-1:0]  k,
  output logic              taken,
  output logic [PC_W-1:0]   target
);
  localparam int EXT_W = PC_W - OFS_W;

  function automatic logic [PC_W-1:0] rel_target(input logic [PC_W-1:0] p,
                                                 input logic [OFS_W-1:0] off);
    logic [PC_W-1:0] sx;
    sx = {{EXT_W{off[OFS_W-1]}}, off};
    return p + sx + PC_W'(1);
  endfunction

  logic cond_bit;
  logic signed_lt;

  assign signed_lt = flags[N_POS] ^ flags[V_POS];
  assign cond_bit  = (sel == IDX_W'(S_POS)) ? signed_lt : flags[sel];
  assign taken     = ((op == OP_BSET) && cond_bit) || ((op == OP_BCLR) && !cond_bit);
  assign target    = rel_target(pc, k);

  a_r11_no_branch: assert property (@(posedge clk) disable iff (!rst_n)
    !((op == OP_BSET) || (op == OP_BCLR)) |-> !taken);
  a_r8_signed_ge: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_BCLR) && (sel == IDX_W'(S_POS))) |-> (taken == (flags[N_POS] == flags[V_POS])));
endmodule

// File: rtl/status_branch_unit.sv
module status_branch_unit
  import sbu_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFS_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_code,
  input  logic [2:0]        bit_sel,
  input  logic [7:0]        alu_we,
  input  logic [7:0]        alu_flags,
  input  logic [7:0]        reg_in,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [OFS_W-1:0]  k_in,
  output logic [7:0]        flags,
  output logic [7:0]        reg_out,
  output logic              taken,
  output logic [PC_W-1:0]   target
);
  sbu_op_e op;
  logic    t_src;

  assign op = sbu_op_e'(op_code);

  sbu_bit_xfer u_xfer (
    .clk(clk), .rst_n(rst_n), .op(op), .sel(bit_sel), .reg_in(reg_in),
    .t_flag(flags[T_POS]), .t_src(t_src), .reg_out(reg_out)
  );

  sbu_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .op(op), .sel(bit_sel), .alu_we(alu_we),
    .alu_flags(alu_flags), .t_src(t_src), .flags_q(flags)
  );

  sbu_branch_eval #(.PC_W(PC_W), .OFS_W(OFS_W)) u_branch (
    .clk(clk), .rst_n(rst_n), .op(op), .sel(bit_sel), .flags(flags),
    .pc(pc_in), .k(k_in), .taken(taken), .target(target)
  );

  a_r10_explicit_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_FSET) && alu_we[bit_sel]) |=> flags[$past(bit_sel)]);
endmodule

// File: tb/status_branch_unit_bench.sv
module status_branch_unit_bench;
  localparam int PC_W  = 10;
  localparam int OFS_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op_code = '0, bit_sel = '0;
  logic [7:0] alu_we = '0, alu_flags = '0, reg_in = '0;
  logic [PC_W-1:0] pc_in = '0;
  logic [OFS_W-1:0] k_in = '0;
  logic [7:0] flags, reg_out;
  logic taken;
  logic [PC_W-1:0] target;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  status_branch_unit #(.PC_W(PC_W), .OFS_W(OFS_W)) u_status_branch_unit (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .bit_sel(bit_sel),
    .alu_we(alu_we), .alu_flags(alu_flags), .reg_in(reg_in), .pc_in(pc_in),
    .k_in(k_in), .flags(flags), .reg_out(reg_out), .taken(taken), .target(target)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // apply one operation for one cycle; at return inputs are idle and we are at a negedge
  task automatic step(input logic [2:0] op, input logic [2:0] sel,
                      input logic [7:0] we, input logic [7:0] af);
    op_code = op; bit_sel = sel; alu_we = we; alu_flags = af;
    @(posedge clk); #2;
    op_code = '0; alu_we = '0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 flags during reset", flags, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags after reset", flags, 8'h00);
  endtask

  task automatic t_alu_mask;
    step(3'd0, 3'd0, 8'hFF, 8'hA5);
    chk("R2 full mask", flags, 8'hA5);
    step(3'd0, 3'd0, 8'h0F, 8'h0A);
    chk("R2 partial mask", flags, 8'hAA);
  endtask

  task automatic t_set_clear;
    step(3'd2, 3'd7, 8'h00, 8'h00);
    chk("R4 clear I", flags, 8'h2A);
    step(3'd1, 3'd0, 8'h00, 8'h00);
    chk("R3 set C", flags, 8'h2B);
    step(3'd2, 3'd5, 8'h00, 8'h00);
    chk("R4 clear H", flags, 8'h0B);
  endtask

  task automatic t_priority;
    // ALU writes all zero except C=1, explicit set of Z in same cycle
    step(3'd1, 3'd1, 8'hFF, 8'h01);
    chk("R10 set beats ALU", flags, 8'h03);
    step(3'd2, 3'd0, 8'h84, 8'h85);
    chk("R10 clear beats ALU", flags, 8'h86);
  endtask

  task automatic t_bit_xfer;
    reg_in = 8'b0000_1000;
    step(3'd3, 3'd3, 8'h00, 8'h00);
    chk("R5 bit store 1 into T", flags, 8'hC6);
    op_code = 3'd4; bit_sel = 3'd0; reg_in = 8'h50; #2;
    chk("R6 bit load sets bit0", reg_out, 8'h51);
    chk("R6 no branch on bit load (R11)", taken, 1'b0);
    op_code = 3'd0; #2;
    chk("R6 passthrough when idle", reg_out, 8'h50);
    @(negedge clk);
    chk("R6 flags unchanged", flags, 8'hC6);
    reg_in = 8'hFF;
    step(3'd3, 3'd6, 8'h00, 8'h00);
    reg_in = 8'h00;
    step(3'd3, 3'd2, 8'h00, 8'h00);
    chk("R5 bit store 0 into T", flags, 8'h86);
    op_code = 3'd4; bit_sel = 3'd7; reg_in = 8'hFF; #2;
    chk("R6 bit load clears bit7", reg_out, 8'h7F);
    op_code = 3'd0;
    @(negedge clk);
  endtask

  task automatic t_branches;
    // flags 0x86: I,N,Z set; C,V,S clear
    op_code = 3'd5; bit_sel = 3'd1; #2;
    chk("R7 branch if Z set", taken, 1'b1);
    op_code = 3'd6; bit_sel = 3'd0; #2;
    chk("R7 same-or-higher C=0", taken, 1'b1);
    op_code = 3'd5; bit_sel = 3'd0; #2;
    chk("R7 lower C=0", taken, 1'b0);
    op_code = 3'd5; bit_sel = 3'd4; #2;
    chk("R8 less-than N^V=1", taken, 1'b1);
    op_code = 3'd6; #2;
    chk("R8 greater-or-equal N^V=1", taken, 1'b0);
    op_code = 3'd0; #2;
    chk("R11 idle not taken", taken, 1'b0);
    @(negedge clk);
    step(3'd1, 3'd3, 8'h00, 8'h00); // V=1 while stored S stays 0
    op_code = 3'd6; bit_sel = 3'd4; #2;
    chk("R8 greater-or-equal N=V=1", taken, 1'b1);
    op_code = 3'd5; #2;
    chk("R8 less-than N=V=1", taken, 1'b0);
    op_code = 3'd1; #2;
    chk("R11 flag set not taken", taken, 1'b0);
    op_code = 3'd0;
    @(negedge clk);
  endtask

  task automatic t_target;
    pc_in = 10'h100; k_in = 7'h40; #2;
    chk("R9 offset -64", target, 10'h0C1);
    pc_in = 10'h010; k_in = 7'h3F; #2;
    chk("R9 offset +63", target, 10'h050);
    pc_in = 10'h3FF; k_in = 7'h00; #2;
    chk("R9 forward wrap", target, 10'h000);
    pc_in = 10'h000; k_in = 7'h7E; #2;
    chk("R9 backward wrap", target, 10'h3FF);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk); #1;
    t_reset();
    t_alu_mask();
    t_set_clear();
    t_priority();
    t_bit_xfer();
    t_branches();
    t_target();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule